// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `WIDTH`-bit operands over several clock cycles using a single `WIDTH`-bit adder/subtractor. It keeps one `2*WIDTH`-bit product register. The high half accumulates partial sums. The low half starts out holding the multiplier and is consumed one bit per step as the register shifts right, so no separate multiplier register exists.

A one-cycle start pulse captures the multiplicand, the multiplier and the sign mode. The block then performs exactly `WIDTH` steps, one per clock. Each step does the following:

- It inspects the product LSB.
- It conditionally adds the multiplicand into the high half.
- It shifts the whole register right by one.

In unsigned mode the carry of the add enters the product MSB. In two's-complement mode the shift is arithmetic, and the last step subtracts instead of adding, so the final step accounts for the negative weight of the multiplier sign bit.

A one-cycle done pulse marks the cycle in which the product is final. The product then holds until the next accepted start.

Top module: `shift_mul`

## Requirements
- R1: An accepted start (start_i high while no operation is in progress) sets product_o to {WIDTH zeros, multiplier_i} in the cycle after the accepting edge.
- R2: With signed_i low at start, the final product_o equals the unsigned product of multiplicand_i and multiplier_i, zero-extended to 2*WIDTH bits.
- R3: With signed_i high at start, both operands are two's complement and the final product_o equals their signed product in 2*WIDTH-bit two's complement (for example 0010 times 1101 gives 1111 1010).
- R4: done_o is high for exactly one cycle, WIDTH clock edges after the edge that accepted start, and product_o is final in that cycle.
- R5: start_i asserted while an operation is in progress is ignored: the operands and mode presented with it do not change the running result or its timing.
- R6: After done_o, product_o keeps its value until the next accepted start.
- R7: After reset, product_o is zero and done_o is low.
- R8: signed_i is sampled only with an accepted start; changes during an operation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, ignored while busy |
| signed_i | input | 1 | 1 selects two's-complement operands |
| multiplicand_i | input | WIDTH | Multiplicand |
| multiplier_i | input | WIDTH | Multiplier |
| product_o | output | 2*WIDTH | Product register |
| done_o | output | 1 | One-cycle pulse when the product is final |

## Verification
The bench builds the block with WIDTH=4. This makes every one of the 256 operand pairs reachable in both unsigned and signed modes, including the most negative operand on either or both sides and the all-ones unsigned corner.

For every operation, the bench checks:

- the loaded register value;
- the exact cycle of the done pulse;
- the held result afterwards.

Further runs inject a conflicting start and flip the mode mid-operation to confirm that both are ignored.

// File: rtl/shift_mul_pkg.sv
package shift_mul_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} acc_op_e;
endpackage

// File: rtl/shift_mul_ctrl.sv
module shift_mul_ctrl #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (cnt_q == CNT_W'(WIDTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CNT_W'(WIDTH));
  assert_ignore_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last_o) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/shift_mul_dp.sv
module shift_mul_dp
  import shift_mul_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [PW-1:0]    prod_o
);
  logic [WIDTH-1:0] x_q;
  logic             sgn_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH-1:0] hi, lo, addend;
  logic [WIDTH:0]   hi_ext, add_ext, acc;
  acc_op_e          op;

  assign hi      = prod_q[PW-1:WIDTH];
  assign lo      = prod_q[WIDTH-1:0];
  assign addend  = lo[0] ? x_q : '0;
  // sign-extend one bit in signed mode so the result never overflows
  assign hi_ext  = {sgn_q & hi[WIDTH-1], hi};
  assign add_ext = {sgn_q & addend[WIDTH-1], addend};
  assign op      = (sgn_q && last_i) ? OP_SUB : OP_ADD;
  assign acc     = (op == OP_SUB) ? hi_ext - add_ext : hi_ext + add_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      sgn_q  <= 1'b0;
      prod_q <= '0;
    end else if (load_i) begin
      x_q    <= mcand_i;
      sgn_q  <= signed_i;
      prod_q <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q <= {acc, lo[WIDTH-1:1]};
    end
  end

  assign prod_o = prod_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(prod_q));
  assert_operands_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ($stable(x_q) && $stable(sgn_q)));
  assert_no_load_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));
endmodule

// File: rtl/shift_mul.sv
module shift_mul #(
  parameter int WIDTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 signed_i,
  input  logic [WIDTH-1:0]     multiplicand_i,
  input  logic [WIDTH-1:0]     multiplier_i,
  output logic [2*WIDTH-1:0]   product_o,
  output logic                 done_o
);
  logic load, step, last;

  shift_mul_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .done_o (done_o)
  );

  shift_mul_dp #(.WIDTH(WIDTH)) i_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .last_i  (last),
    .signed_i(signed_i),
    .mcand_i (multiplicand_i),
    .mplier_i(multiplier_i),
    .prod_o  (product_o)
  );

  assert_done_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(step) && !step);
endmodule

// File: tb/test_shift_mul.sv
module test_shift_mul;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sgn = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic [PW-1:0] prod;
  logic          done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shift_mul #(.WIDTH(W)) i_shift_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .multiplicand_i(a), .multiplier_i(b), .product_o(prod), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] expect_prod(input logic [W-1:0] x, input logic [W-1:0] y,
                                                input bit s);
    int xi, yi;
    xi = int'(x);
    yi = int'(y);
    if (s) begin
      if (x[W-1]) xi = xi - (1 << W);
      if (y[W-1]) yi = yi - (1 << W);
    end
    return PW'(xi * yi);
  endfunction

  // disturb: 1 = conflicting start mid-run, 2 = flip mode mid-run
  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input bit s, input int disturb);
    logic [PW-1:0] exp;
    exp = expect_prod(x, y, s);
    @(negedge clk);
    a = x; b = y; sgn = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(prod == {{W{1'b0}}, y}, "R1 load", prod, {{W{1'b0}}, y});
    for (int k = 1; k <= W; k++) begin
      if (k == 2 && disturb == 1) begin
        a = ~x; b = ~y; sgn = ~s; start = 1'b1;
      end
      if (k == 2 && disturb == 2) sgn = ~s;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (k < W) chk(done == 1'b0, "R4 early done", done, 0);
    end
    chk(done == 1'b1, "R4 done timing", done, 1);
    if (disturb == 1)      chk(prod == exp, "R5 start ignored", prod, exp);
    else if (disturb == 2) chk(prod == exp, "R8 mode sampled", prod, exp);
    else if (s)            chk(prod == exp, "R3 signed product", prod, exp);
    else                   chk(prod == exp, "R2 unsigned product", prod, exp);
    a = ~x; b = ~y;
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single cycle", done, 0);
    chk(prod == exp, "R6 hold", prod, exp);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prod == '0, "R7 reset product", prod, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    run(4'b0010, 4'b0011, 1'b0, 0);
    chk(prod == 8'b0000_0110, "R2 2x3", prod, 8'h06);
    run(4'b0010, 4'b1101, 1'b1, 0);
    chk(prod == 8'b1111_1010, "R3 2x-3", prod, 8'hFA);
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < (1 << W); x++)
        for (int y = 0; y < (1 << W); y++)
          run(W'(x), W'(y), s[0], 0);
    run(4'b1000, 4'b1000, 1'b1, 1);
    run(4'b1111, 4'b1111, 1'b0, 1);
    run(4'b0111, 4'b1001, 1'b1, 2);
    run(4'b1011, 4'b1101, 1'b0, 2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule